// File: doc/BRIEF.md
# CPU Standby Mode Sequencer

This block sequences the two standby modes of a small 8-bit CPU core. The instruction decoder raises a one-cycle strobe when it has decoded a wait or a stop instruction. The sequencer then gates off the CPU clock and clears the interrupt-mask bit of the condition code register. It also watches a general interrupt request, an external interrupt request and reset, and brings the core back to normal running.

A light standby (wait) ends on any interrupt. A deep standby (stop) ends only on an external interrupt. After a stop exit, the CPU clock stays gated for a parameterized oscillator settling time, `STAB_CYCLES` clocks, 4096 by default. The current mode is reported on a two-bit output.

When standby ends through an interrupt, the mask bit stays clear. When it ends through reset, the mask bit is set. Reset is asynchronous and active high, and it wins over every other input.

Top module: `standby_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mode` is 2'b00 (run), `cpuClkEn` is 1 and `iMask` is 1.
- R2: A `waitExec` pulse in run mode makes `mode` 2'b01 (wait) from the next cycle on, with `cpuClkEn` 0 and `iMask` 0.
- R3: A `stopExec` pulse in run mode makes `mode` 2'b10 (stop) from the next cycle on, with `cpuClkEn` 0 and `iMask` 0. When both strobes arrive in the same cycle, stop is taken.
- R4: In wait mode, either `irqReq` or `extIrqReq` returns the block to run on the next cycle, with `cpuClkEn` 1 and `iMask` still 0.
- R5: In stop mode, `irqReq` alone has no effect: the block stays in stop with the clock gated.
- R6: In stop mode, `extIrqReq` moves the block to mode 2'b11 (settling) on the next cycle. It stays there, with `cpuClkEn` 0, for exactly `STAB_CYCLES` cycles. It then enters run with `iMask` still 0.
- R7: The `waitExec` and `stopExec` strobes are ignored in every mode other than run. Interrupt requests are ignored during settling.
- R8: Reset taken from wait, stop or settling returns the block to run with `cpuClkEn` 1 and `iMask` 1.
- R9: In run mode, interrupt requests have no effect on `mode` or `iMask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Asynchronous reset, active high |
| waitExec | input | 1 | One-cycle strobe: wait instruction decoded |
| stopExec | input | 1 | One-cycle strobe: stop instruction decoded |
| irqReq | input | 1 | General (internal) interrupt request |
| extIrqReq | input | 1 | External interrupt request |
| cpuClkEn | output | 1 | CPU clock enable |
| iMask | output | 1 | Interrupt-mask bit of the condition code register |
| mode | output | 2 | 00 run, 01 wait, 10 stop, 11 settling |

## Verification
A wrong state register shows on `mode` and `cpuClkEn` in the very next cycle, because both are read directly from the state. A corrupted settling counter gives no sign during the settle itself. It shows only as an early or late return to run, so the bench counts every settling cycle of a full 4096-cycle window. A mask bit that is lost or set falsely shows on `iMask` right after an interrupt exit. That is why each exit path is followed by a mask check.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_WAIT    = 2'b01,
    MODE_STOP    = 2'b10,
    MODE_RECOVER = 2'b11
  } mode_e;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic clrMask;
  } dpCtrl_t;
endpackage

// File: rtl/standby_dp.sv
module standby_dp
  import standby_pkg::*;
#(
  parameter int STAB_CYCLES = 4096
) (
  input  logic    clk,
  input  logic    rst,
  input  dpCtrl_t ctrl,
  output logic    cntZero,
  output logic    iMask
);
  localparam int CW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt <= '0;
    end else if (ctrl.loadCnt) begin
      cnt <= LOAD_VAL;
    end else if (ctrl.decCnt) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      iMask <= 1'b1;
    end else if (ctrl.clrMask) begin
      iMask <= 1'b0;
    end
  end

  // R6
  dec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.decCnt |-> !cntZero);

  // R8
  mask_only_reset_sets_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(iMask));

  // R2
  mask_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.clrMask |=> !iMask);
endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    waitExec,
  input  logic    stopExec,
  input  logic    irqReq,
  input  logic    extIrqReq,
  input  logic    cntZero,
  output mode_e   state,
  output dpCtrl_t ctrl
);
  mode_e nxt;

  always_comb begin
    nxt  = state;
    ctrl = '0;
    unique case (state)
      MODE_RUN: begin
        if (stopExec) begin
          nxt          = MODE_STOP;
          ctrl.clrMask = 1'b1;
        end else if (waitExec) begin
          nxt          = MODE_WAIT;
          ctrl.clrMask = 1'b1;
        end
      end
      MODE_WAIT: begin
        if (irqReq || extIrqReq) nxt = MODE_RUN;
      end
      MODE_STOP: begin
        if (extIrqReq) begin
          nxt          = MODE_RECOVER;
          ctrl.loadCnt = 1'b1;
        end
      end
      MODE_RECOVER: begin
        if (cntZero) nxt = MODE_RUN;
        else         ctrl.decCnt = 1'b1;
      end
      default: nxt = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= MODE_RUN;
    else     state <= nxt;
  end

  // R3
  stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_RUN && stopExec) |=> state == MODE_STOP);

  // R4
  wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_WAIT && (irqReq || extIrqReq)) |=> state == MODE_RUN);

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_STOP && !extIrqReq) |=> state == MODE_STOP);

  // R6
  stop_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_STOP && extIrqReq) |=> state == MODE_RECOVER);

  // R7
  recover_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_RECOVER && !cntZero) |=> state == MODE_RECOVER);
endmodule

// File: rtl/standby_seq.sv
module standby_seq
  import standby_pkg::*;
#(
  parameter int STAB_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       waitExec,
  input  logic       stopExec,
  input  logic       irqReq,
  input  logic       extIrqReq,
  output logic       cpuClkEn,
  output logic       iMask,
  output logic [1:0] mode
);
  mode_e   state;
  dpCtrl_t ctrl;
  logic    cntZero;

  standby_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .waitExec  (waitExec),
    .stopExec  (stopExec),
    .irqReq    (irqReq),
    .extIrqReq (extIrqReq),
    .cntZero   (cntZero),
    .state     (state),
    .ctrl      (ctrl)
  );

  standby_dp #(.STAB_CYCLES(STAB_CYCLES)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .cntZero (cntZero),
    .iMask   (iMask)
  );

  assign cpuClkEn = (state == MODE_RUN);
  assign mode     = state;

  // R6
  no_direct_wake_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpuClkEn) |-> $past(state) != MODE_STOP);

  // R4
  wake_mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpuClkEn) |-> !iMask);
endmodule

// File: tb/standby_seq_test.sv
module standby_seq_test;
  localparam int STAB = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic waitExec = 1'b0, stopExec = 1'b0, irqReq = 1'b0, extIrqReq = 1'b0;
  logic cpuClkEn, iMask;
  logic [1:0] mode;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  standby_seq #(.STAB_CYCLES(STAB)) uut (
    .clk(clk), .rst(rst), .waitExec(waitExec), .stopExec(stopExec),
    .irqReq(irqReq), .extIrqReq(extIrqReq),
    .cpuClkEn(cpuClkEn), .iMask(iMask), .mode(mode)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input int expMode, input int expClk, input int expMask);
    check(req, "mode", int'(mode), expMode);
    check(req, "cpuClkEn", int'(cpuClkEn), expClk);
    check(req, "iMask", int'(iMask), expMask);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    #1;
    checkAll("R1", 0, 1, 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkAll("R1", 0, 1, 1);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic tRunIrq();
    irqReq = 1'b1; extIrqReq = 1'b1;
    @(negedge clk); @(negedge clk);
    irqReq = 1'b0; extIrqReq = 1'b0;
    checkAll("R9", 0, 1, 1);
  endtask

  task automatic tWait(input bit useExt);
    doReset();
    pulse(waitExec);
    checkAll("R2", 1, 0, 0);
    @(negedge clk);
    pulse(stopExec);
    check("R7", "strobe in wait", int'(mode), 1);
    if (useExt) pulse(extIrqReq); else pulse(irqReq);
    checkAll("R4", 0, 1, 0);
  endtask

  task automatic tStop();
    doReset();
    pulse(stopExec);
    checkAll("R3", 2, 0, 0);
    pulse(irqReq);
    checkAll("R5", 2, 0, 0);
    pulse(waitExec);
    check("R7", "strobe in stop", int'(mode), 2);
    pulse(extIrqReq);
    begin
      int cnt = 0;
      while (mode == 2'b11 && cnt < STAB + 10) begin
        check("R6", "clock gated while settling", int'(cpuClkEn), 0);
        if (cnt == 5) begin
          irqReq = 1'b1; extIrqReq = 1'b1; stopExec = 1'b1;
        end
        if (cnt == 6) begin
          irqReq = 1'b0; extIrqReq = 1'b0; stopExec = 1'b0;
        end
        cnt++;
        @(negedge clk);
      end
      check("R6", "settling cycles", cnt, STAB);
      check("R7", "interrupts ignored in settling", cnt, STAB);
    end
    checkAll("R6", 0, 1, 0);
  endtask

  task automatic tBoth();
    doReset();
    waitExec = 1'b1; stopExec = 1'b1;
    @(negedge clk);
    waitExec = 1'b0; stopExec = 1'b0;
    checkAll("R3", 2, 0, 0);
  endtask

  task automatic tResetFrom(input int which);
    doReset();
    if (which == 0) pulse(waitExec);
    else pulse(stopExec);
    if (which == 2) begin
      pulse(extIrqReq);
      repeat (3) @(negedge clk);
      check("R8", "in settling", int'(mode), 3);
    end
    rst = 1'b1;
    #1;
    checkAll("R8", 0, 1, 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkAll("R8", 0, 1, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    doReset();
    tRunIrq();
    tWait(1'b0);
    tWait(1'b1);
    tStop();
    tBoth();
    tResetFrom(0);
    tResetFrom(1);
    tResetFrom(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule